// File: doc/BRIEF.md
# Branch Condition Evaluator

This block sits in the execute stage of a small 16-bit processor. Each time the sequencer presents a branch it decides two things: whether the branch is taken, and which program counter value comes next. The decision uses a four-bit condition code. One code means the branch is always taken. Each of the other codes picks one bit of an eight-bit flag word and the polarity that bit must have.

The block handles four kinds of branch. The immediate form jumps to an operand fetched with the instruction. The register-indirect form jumps to the value held in a pointer register. The relative form adds a signed offset operand to the address of the current instruction. The relative-indirect form adds the pointer register value to that address instead.

When the branch is not taken, the block returns the sequential PC supplied by the fetch logic. When the class is not a branch class, it also returns the sequential PC and reports the branch as not taken. A request is marked by a one-cycle strobe. The result is registered and appears on the next clock edge, together with a one-cycle valid pulse.

Top module: `branch_cond_eval`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `res_valid`, `taken` and `next_pc` are all 0.
- R2: A strobe on `br_valid` gives `res_valid` = 1 exactly one clock later. `res_valid` is 0 in every cycle that does not follow a strobe. `taken` and `next_pc` keep their values until the next strobe.
- R3: Condition code 0 makes a branch class always taken, whatever value the flags hold.
- R4: Codes 1 to 8 test the low flags as follows. Code 1 is taken when flag0=1, code 2 when flag0=0, code 3 when flag1=1, code 4 when flag1=0, code 5 when flag2=1, code 6 when flag2=0, code 7 when flag3=1 and code 8 when flag3=0.
- R5: Codes 9 to 15 follow the same pattern on flag4 to flag7. Odd codes test for a 1, even codes test for a 0, and the flag tested is (code-1)/2. With all flags at 0 (their state after reset), codes 10, 12 and 14 are taken and codes 9, 11, 13 and 15 are not.
- R6: For class 2 (immediate), a taken branch gives `next_pc` = `operand`.
- R7: For class 1 (register indirect), a taken branch gives `next_pc` = `ptr_val`.
- R8: For class 5 (relative), a taken branch gives `next_pc` = (`cur_pc` + `operand`) mod 2^16. The operand is read as a signed offset.
- R9: For class 6 (relative indirect), a taken branch gives `next_pc` = (`cur_pc` + `ptr_val`) mod 2^16.
- R10: A branch whose condition fails gives `taken` = 0 and `next_pc` = `seq_pc`.
- R11: Any class other than 1, 2, 5 or 6 gives `taken` = 0 and `next_pc` = `seq_pc`, whatever the condition code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | One-cycle strobe that requests an evaluation |
| br_class | input | 4 | Instruction class (1, 2, 5 and 6 are branch classes) |
| cond_code | input | 4 | Condition code taken from instruction bits 11:8 |
| flags | input | 8 | Flag word; bit n is flag n |
| cur_pc | input | 16 | Address of the current instruction |
| seq_pc | input | 16 | Sequential next address |
| operand | input | 16 | Fetched absolute target or signed offset |
| ptr_val | input | 16 | Value of the pointer register |
| res_valid | output | 1 | Result strobe, one cycle after `br_valid` |
| taken | output | 1 | Branch taken |
| next_pc | output | 16 | Address to fetch next |

## Verification
Two functions are always active in the same cycle: evaluating the condition and computing the target. Every relative branch forms its sum, even when the condition then rejects it. The bench provokes this case with relative and relative-indirect requests whose sums wrap past 0xFFFF and whose condition is a reserved code that fails because all flags are 0. It then issues the same requests with a passing code. A failing condition must return `seq_pc` and discard the computed sum. A passing condition must return the wrapped sum.

// File: rtl/bce_pkg.sv
package bce_pkg;

    localparam int unsigned CLASS_W = 4;

    // Class values are fixed by the instruction encoding
    localparam logic [CLASS_W-1:0] CLS_REGX = 4'd1;
    localparam logic [CLASS_W-1:0] CLS_IMM  = 4'd2;
    localparam logic [CLASS_W-1:0] CLS_REL  = 4'd5;
    localparam logic [CLASS_W-1:0] CLS_RELX = 4'd6;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_ABSOLUTE,
        TGT_RELATIVE
    } tgt_kind_e;

    typedef struct packed {
        tgt_kind_e kind;
        logic      use_ptr;
    } tgt_sel_t;

    function automatic tgt_sel_t decode_class(input logic [CLASS_W-1:0] cls);
        tgt_sel_t s;
        s.kind    = TGT_NONE;
        s.use_ptr = 1'b0;
        case (cls)
            CLS_IMM:  s.kind = TGT_ABSOLUTE;
            CLS_REGX: begin s.kind = TGT_ABSOLUTE; s.use_ptr = 1'b1; end
            CLS_REL:  s.kind = TGT_RELATIVE;
            CLS_RELX: begin s.kind = TGT_RELATIVE; s.use_ptr = 1'b1; end
            default:  s.kind = TGT_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/bce_cond_eval.sv
module bce_cond_eval #(
    parameter int unsigned FLAG_W = 8,
    localparam int unsigned IDX_W = $clog2(FLAG_W),
    localparam int unsigned CODE_W = IDX_W + 1
) (
    input  logic [CODE_W-1:0] code,
    input  logic [FLAG_W-1:0] flags,
    output logic              pass
);
    logic [CODE_W-1:0] code_m1;
    logic [IDX_W-1:0]  idx;
    logic              want;
    logic [FLAG_W-1:0] match;

    assign code_m1 = code - 1'b1;
    assign idx     = code_m1[CODE_W-1:1];
    assign want    = ~code_m1[0];

    // One polarity comparator per flag; the index then picks one of them
    for (genvar g = 0; g < FLAG_W; g++) begin : g_match
        assign match[g] = (flags[g] == want);
    end

    always_comb begin
        if (code == '0) pass = 1'b1;
        else            pass = match[idx];
    end
endmodule

// File: rtl/bce_target_gen.sv
module bce_target_gen
    import bce_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic [CLASS_W-1:0] cls,
    input  logic [ADDR_W-1:0]  cur_pc,
    input  logic [ADDR_W-1:0]  operand,
    input  logic [ADDR_W-1:0]  ptr_val,
    output logic [ADDR_W-1:0]  target,
    output logic               is_branch
);
    tgt_sel_t          sel;
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] rel_sum;

    assign sel       = decode_class(cls);
    assign src       = sel.use_ptr ? ptr_val : operand;
    assign rel_sum   = cur_pc + src;
    assign is_branch = (sel.kind != TGT_NONE);

    always_comb begin
        case (sel.kind)
            TGT_ABSOLUTE: target = src;
            TGT_RELATIVE: target = rel_sum;
            default:      target = '0;
        endcase
    end
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
    import bce_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned FLAG_W = 8,
    localparam int unsigned CODE_W = $clog2(FLAG_W) + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               br_valid,
    input  logic [CLASS_W-1:0] br_class,
    input  logic [CODE_W-1:0]  cond_code,
    input  logic [FLAG_W-1:0]  flags,
    input  logic [ADDR_W-1:0]  cur_pc,
    input  logic [ADDR_W-1:0]  seq_pc,
    input  logic [ADDR_W-1:0]  operand,
    input  logic [ADDR_W-1:0]  ptr_val,
    output logic               res_valid,
    output logic               taken,
    output logic [ADDR_W-1:0]  next_pc
);
    logic              cond_pass;
    logic              is_branch;
    logic [ADDR_W-1:0] target;
    logic              take_d;
    logic [ADDR_W-1:0] pc_d;

    bce_cond_eval #(.FLAG_W(FLAG_W)) u_cond (
        .code  (cond_code),
        .flags (flags),
        .pass  (cond_pass)
    );

    bce_target_gen #(.ADDR_W(ADDR_W)) u_tgt (
        .cls       (br_class),
        .cur_pc    (cur_pc),
        .operand   (operand),
        .ptr_val   (ptr_val),
        .target    (target),
        .is_branch (is_branch)
    );

    assign take_d = is_branch & cond_pass;
    assign pc_d   = take_d ? target : seq_pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            taken     <= 1'b0;
            next_pc   <= '0;
        end else begin
            res_valid <= br_valid;
            if (br_valid) begin
                taken   <= take_d;
                next_pc <= pc_d;
            end
        end
    end

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        br_valid |=> res_valid);

    // R3
    uncond_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (br_valid && cond_code == '0 &&
         (br_class == CLS_IMM || br_class == CLS_REGX ||
          br_class == CLS_REL || br_class == CLS_RELX)) |=> taken);

    // R10
    fallthrough_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !taken) |-> next_pc == $past(seq_pc));

    // R11
    non_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (br_valid && br_class != CLS_IMM && br_class != CLS_REGX &&
         br_class != CLS_REL && br_class != CLS_RELX) |=> !taken);

    // R8
    rel_target_chk: assert property (@(posedge clk) disable iff (rst)
        (br_valid && br_class == CLS_REL) |=>
        (!taken || next_pc == ADDR_W'($past(cur_pc) + $past(operand))));
endmodule

// File: tb/tb_branch_cond_eval.sv
module tb_branch_cond_eval;
    logic        clk = 1'b0;
    logic        rst;
    logic        br_valid;
    logic [3:0]  br_class;
    logic [3:0]  cond_code;
    logic [7:0]  flags;
    logic [15:0] cur_pc, seq_pc, operand, ptr_val;
    logic        res_valid, taken;
    logic [15:0] next_pc;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    branch_cond_eval dut (
        .clk(clk), .rst(rst), .br_valid(br_valid), .br_class(br_class),
        .cond_code(cond_code), .flags(flags), .cur_pc(cur_pc), .seq_pc(seq_pc),
        .operand(operand), .ptr_val(ptr_val), .res_valid(res_valid),
        .taken(taken), .next_pc(next_pc)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_cond(input logic [3:0] c, input logic [7:0] f);
        case (c)
            4'd0:  return 1'b1;
            4'd1:  return f[0];
            4'd2:  return !f[0];
            4'd3:  return f[1];
            4'd4:  return !f[1];
            4'd5:  return f[2];
            4'd6:  return !f[2];
            4'd7:  return f[3];
            4'd8:  return !f[3];
            4'd9:  return f[4];
            4'd10: return !f[4];
            4'd11: return f[5];
            4'd12: return !f[5];
            4'd13: return f[6];
            4'd14: return !f[6];
            default: return f[7];
        endcase
    endfunction

    // Drive at negedge, capture at posedge, sample at following negedge
    task automatic issue(input logic [3:0] cls, input logic [3:0] cc, input logic [7:0] fl,
                         input logic [15:0] cp, input logic [15:0] sp,
                         input logic [15:0] op, input logic [15:0] pv);
        @(negedge clk);
        br_class = cls; cond_code = cc; flags = fl;
        cur_pc = cp; seq_pc = sp; operand = op; ptr_val = pv;
        br_valid = 1'b1;
        @(negedge clk);
        br_valid = 1'b0;
    endtask

    task automatic expect_res(input string req, input logic t_exp, input logic [15:0] pc_exp);
        check(res_valid == 1'b1, {req, " valid"}, res_valid, 1);
        check(taken == t_exp, {req, " taken"}, taken, t_exp);
        check(next_pc == pc_exp, {req, " next_pc"}, next_pc, pc_exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(res_valid == 0 && taken == 0, "R1 reset outputs", {res_valid, taken}, 0);
        check(next_pc == 16'h0, "R1 reset next_pc", next_pc, 0);
        rst = 1'b0;
        @(negedge clk);
        check(res_valid == 0 && taken == 0 && next_pc == 0, "R1 after release",
              {res_valid, taken}, 0);
    endtask

    task automatic t_uncond();
        // R3: code 0 is taken under any flags, for each branch class
        issue(4'd2, 4'd0, 8'hFF, 16'h0100, 16'h0102, 16'h03FF, 16'h1111);
        expect_res("R3 R6 imm uncond", 1'b1, 16'h03FF);
        issue(4'd1, 4'd0, 8'h00, 16'h0100, 16'h0101, 16'h0000, 16'h2468);
        expect_res("R3 R7 regx uncond", 1'b1, 16'h2468);
    endtask

    task automatic t_low_codes();
        // R4: every low code against two flag patterns
        for (int c = 1; c <= 8; c++) begin
            for (int p = 0; p < 2; p++) begin
                logic [7:0] fl;
                logic       e;
                fl = p ? 8'h05 : 8'h0A;
                e  = exp_cond(4'(c), fl);
                issue(4'd2, 4'(c), fl, 16'h0200, 16'h0202, 16'h0ABC, 16'h0);
                expect_res("R4 low code", e, e ? 16'h0ABC : 16'h0202);
            end
        end
    endtask

    task automatic t_reserved_codes();
        // R5: all flags zero after reset, then single-bit patterns
        for (int c = 9; c <= 15; c++) begin
            logic e;
            e = ((c % 2) == 0);
            issue(4'd2, 4'(c), 8'h00, 16'h0300, 16'h0302, 16'h0777, 16'h0);
            expect_res("R5 reserved zero flags", e, e ? 16'h0777 : 16'h0302);
        end
        for (int c = 9; c <= 15; c++) begin
            logic [7:0] fl;
            logic       e;
            fl = 8'h01 << ((c - 1) / 2);
            e  = exp_cond(4'(c), fl);
            issue(4'd1, 4'(c), fl, 16'h0300, 16'h0301, 16'h0, 16'h0555);
            expect_res("R5 reserved flag set", e, e ? 16'h0555 : 16'h0301);
        end
    endtask

    task automatic t_relative();
        issue(4'd5, 4'd0, 8'h00, 16'h1000, 16'h1002, 16'h0008, 16'h0);
        expect_res("R8 rel fwd", 1'b1, 16'h1008);
        issue(4'd5, 4'd1, 8'h01, 16'h1000, 16'h1002, 16'hFFF0, 16'h0);
        expect_res("R8 rel back", 1'b1, 16'h0FF0);
        issue(4'd6, 4'd2, 8'h00, 16'h2000, 16'h2001, 16'h0, 16'h0040);
        expect_res("R9 relx fwd", 1'b1, 16'h2040);
        issue(4'd6, 4'd0, 8'h00, 16'h0010, 16'h0011, 16'h0, 16'h8000);
        expect_res("R9 relx neg", 1'b1, 16'h8010);
    endtask

    task automatic t_wrap_with_fail();
        // Target sums wrap; failing reserved code must return seq_pc
        issue(4'd5, 4'd9, 8'h00, 16'hFFF0, 16'hFFF2, 16'h0020, 16'h0);
        expect_res("R10 rel wrap fail", 1'b0, 16'hFFF2);
        issue(4'd5, 4'd10, 8'h00, 16'hFFF0, 16'hFFF2, 16'h0020, 16'h0);
        expect_res("R8 rel wrap pass", 1'b1, 16'h0010);
        issue(4'd6, 4'd15, 8'h00, 16'hFF00, 16'hFF01, 16'h0, 16'h0200);
        expect_res("R10 relx wrap fail", 1'b0, 16'hFF01);
        issue(4'd6, 4'd14, 8'h00, 16'hFF00, 16'hFF01, 16'h0, 16'h0200);
        expect_res("R9 relx wrap pass", 1'b1, 16'h0100);
    endtask

    task automatic t_non_branch();
        for (int c = 0; c < 16; c++) begin
            if (c == 1 || c == 2 || c == 5 || c == 6) continue;
            issue(4'(c), 4'd0, 8'hFF, 16'h4000, 16'h4003, 16'h1234, 16'h5678);
            expect_res("R11 non-branch class", 1'b0, 16'h4003);
        end
    endtask

    task automatic t_latency();
        issue(4'd2, 4'd0, 8'h00, 16'h0500, 16'h0502, 16'h0BEE, 16'h0);
        expect_res("R2 strobe", 1'b1, 16'h0BEE);
        br_class = 4'd3; seq_pc = 16'h9999;
        @(negedge clk);
        check(res_valid == 0, "R2 valid drops", res_valid, 0);
        check(taken == 1 && next_pc == 16'h0BEE, "R2 hold", next_pc, 16'h0BEE);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; br_valid = 1'b0; br_class = '0; cond_code = '0; flags = '0;
        cur_pc = '0; seq_pc = '0; operand = '0; ptr_val = '0;
        repeat (2) @(posedge clk);
        t_reset();
        t_uncond();
        t_low_codes();
        t_reserved_codes();
        t_relative();
        t_wrap_with_fail();
        t_non_branch();
        t_latency();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule